// File: doc/BRIEF.md
# Clock Stop Controller

This block sits between a clock generator and its output pins. It gates two groups of clocks: a CPU group, driven as true and complement pairs, and a PCI group of single-ended outputs. Each group has its own active-low stop request. Each output has a configuration bit that marks it as stoppable or free-running, and a second bit that enables or disables it. The stop request is synchronised into each clock domain. The gate for each output is registered on the falling edge of that output's source clock. As a result an output starts or stops only while its source clock is low, and every high pulse it drives has full width.

A stopped or disabled CPU output releases its pins: its output-enable goes low, and the true and complement lines are left to float. A stopped or disabled PCI output is held low and stays driven. Free-running outputs ignore the stop request of their group.

Top module: `clkstop_ctrl`

## Requirements
- R1: A stop request on `cpu_stop_n_i` (level 0) that is present at two consecutive falling edges of `cpu_clk_i` gates the stoppable CPU outputs. The first rising edge of `cpu_clk_i` after the request is driven still passes to the output. The second rising edge does not.
- R2: A CPU output stops only when its bit in `cpu_stoppable_i` is 1. When the bit is 0 the output keeps toggling while the request is active.
- R3: A CPU output that is not running drives its bit of `cpu_oe_o` to 0, which places both `cpu_t_o` and `cpu_c_o` in high impedance. A running CPU output drives its bit of `cpu_oe_o` to 1.
- R4: After `cpu_stop_n_i` returns to 1, a stopped CPU output passes again the second rising edge of `cpu_clk_i` after the release. It does not pass the first.
- R5: A stop request on `pci_stop_n_i` (level 0) holds low every PCI output whose bit in `pci_stoppable_i` is 1. The request takes effect after two falling edges of `pci_clk_i`, and the PCI outputs stay driven (`pci_oe_o` is all ones). Outputs whose bit is 0 keep toggling.
- R6: After `pci_stop_n_i` returns to 1, a stopped PCI output passes again the second rising edge of `pci_clk_i` after the release.
- R7: An output whose enable bit (`cpu_en_i` or `pci_en_i`) is 0 is off whatever the stop inputs are: a CPU output floats, and a PCI output is held low.
- R8: Every high pulse on a gated output lasts exactly one high phase of its source clock. No shortened pulse appears when a gate opens or closes.
- R9: While a CPU output is driven, `cpu_c_o` is the inverse of `cpu_t_o`.
- R10: While `rst_n` is 0, every CPU output-enable is 0 and every gated clock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Source clock of the CPU group |
| pci_clk_i | input | 1 | Source clock of the PCI group |
| cpu_stop_n_i | input | 1 | Active-low stop request for the CPU group |
| pci_stop_n_i | input | 1 | Active-low stop request for the PCI group |
| cpu_en_i | input | N_CPU | Per-output enable, CPU group |
| cpu_stoppable_i | input | N_CPU | Per-output mode for the CPU group: 1 stoppable, 0 free-running |
| pci_en_i | input | N_PCI | Per-output enable, PCI group |
| pci_stoppable_i | input | N_PCI | Per-output mode for the PCI group: 1 stoppable, 0 free-running |
| cpu_t_o | output | N_CPU | Gated true CPU clocks |
| cpu_c_o | output | N_CPU | Complement CPU clocks |
| cpu_oe_o | output | N_CPU | CPU pin drive enable (0 means high impedance) |
| pci_o | output | N_PCI | Gated PCI clocks |
| pci_oe_o | output | N_PCI | PCI pin drive enable (always 1) |

## Verification
The bench builds the block with N_CPU = 2 and N_PCI = 4. With these sizes it can step through every combination of enable vector, stoppable vector and stop level: 32 combinations for the CPU group and 512 for the PCI group. It compares the settled outputs against a model of the form enable AND NOT (stop AND stoppable). Separate runs drive the request just after a rising edge and confirm the exact edge on which each group stops and resumes. A pulse-width monitor on every gated output watches for runt pulses across all of these transitions.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // How a group presents an output that is not running.
  typedef enum logic {
    STOP_DRIVE_LOW = 1'b0,
    STOP_FLOAT     = 1'b1
  } stop_style_e;

  // Gate state for the next low phase of the source clock.
  function automatic logic gate_next(input logic enabled,
                                     input logic stop_req,
                                     input logic stoppable);
    return enabled & ~(stop_req & stoppable);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// First capture stage of the stop request. It samples on the falling edge
// of the source clock, which is the rising edge of the complement clock.
module clkstop_sync (
  input  logic clk_i,
  input  logic rst_n,
  input  logic stop_n_i,
  output logic req_o
);
  logic req_q;

  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= ~stop_n_i;
  end

  assign req_o = req_q;

  // R1: a low request at one sampling edge is visible one edge later
  p_sync_capture_r1: assert property (@(negedge clk_i) disable iff (!rst_n)
    (!stop_n_i) |=> req_q);

endmodule

// File: rtl/clkstop_cell.sv
`timescale 1ns/1ps
// One gated output. The gate register is the second synchroniser stage. It
// changes only on the falling edge, so the AND gate switches while the clock
// is low.
module clkstop_cell
  import clkstop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  input  logic stoppable_i,
  input  logic stop_req_i,
  output logic run_o,
  output logic clk_o
);
  logic run_q;

  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= gate_next(en_i, stop_req_i, stoppable_i);
  end

  assign run_o = run_q;
  assign clk_o = clk_i & run_q;

  // R2: a captured request on a stoppable output closes the gate
  p_stop_honoured_r2: assert property (@(negedge clk_i) disable iff (!rst_n)
    (stop_req_i && stoppable_i) |=> !run_q);

  // R2 / R5: a free-running enabled output stays open
  p_freerun_kept_r5: assert property (@(negedge clk_i) disable iff (!rst_n)
    (en_i && !stoppable_i) |=> run_q);

  // R4: once the request is gone an enabled output reopens
  p_release_r4: assert property (@(negedge clk_i) disable iff (!rst_n)
    (!stop_req_i && en_i) |=> run_q);

  // R7: disable wins over everything
  p_disable_wins_r7: assert property (@(negedge clk_i) disable iff (!rst_n)
    (!en_i) |=> !run_q);

endmodule

// File: rtl/clkstop_group.sv
`timescale 1ns/1ps
// One clock group: a shared request synchroniser and one cell per output.
module clkstop_group
  import clkstop_pkg::*;
#(
  parameter int          WIDTH = 2,
  parameter stop_style_e STYLE = STOP_DRIVE_LOW
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             stop_n_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] stoppable_i,
  output logic [WIDTH-1:0] clk_o,
  output logic [WIDTH-1:0] oe_o
);
  localparam logic [WIDTH-1:0] DRIVE_ALWAYS = (STYLE == STOP_FLOAT) ? '0 : '1;

  logic             stop_req;
  logic [WIDTH-1:0] run;

  clkstop_sync u_sync (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .stop_n_i (stop_n_i),
    .req_o    (stop_req)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    clkstop_cell u_cell (
      .clk_i       (clk_i),
      .rst_n       (rst_n),
      .en_i        (en_i[i]),
      .stoppable_i (stoppable_i[i]),
      .stop_req_i  (stop_req),
      .run_o       (run[i]),
      .clk_o       (clk_o[i])
    );
  end

  // A floating group releases the pins of idle outputs. A low-held group
  // keeps driving them.
  assign oe_o = run | DRIVE_ALWAYS;

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_CPU = 2,
  parameter int N_PCI = 8
) (
  input  logic             rst_n,
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             cpu_stop_n_i,
  input  logic             pci_stop_n_i,
  input  logic [N_CPU-1:0] cpu_en_i,
  input  logic [N_CPU-1:0] cpu_stoppable_i,
  input  logic [N_PCI-1:0] pci_en_i,
  input  logic [N_PCI-1:0] pci_stoppable_i,
  output logic [N_CPU-1:0] cpu_t_o,
  output logic [N_CPU-1:0] cpu_c_o,
  output logic [N_CPU-1:0] cpu_oe_o,
  output logic [N_PCI-1:0] pci_o,
  output logic [N_PCI-1:0] pci_oe_o
);
  logic [N_CPU-1:0] cpu_gated;

  clkstop_group #(.WIDTH(N_CPU), .STYLE(STOP_FLOAT)) u_cpu (
    .clk_i       (cpu_clk_i),
    .rst_n       (rst_n),
    .stop_n_i    (cpu_stop_n_i),
    .en_i        (cpu_en_i),
    .stoppable_i (cpu_stoppable_i),
    .clk_o       (cpu_gated),
    .oe_o        (cpu_oe_o)
  );

  clkstop_group #(.WIDTH(N_PCI), .STYLE(STOP_DRIVE_LOW)) u_pci (
    .clk_i       (pci_clk_i),
    .rst_n       (rst_n),
    .stop_n_i    (pci_stop_n_i),
    .en_i        (pci_en_i),
    .stoppable_i (pci_stoppable_i),
    .clk_o       (pci_o),
    .oe_o        (pci_oe_o)
  );

  assign cpu_t_o = cpu_gated;
  assign cpu_c_o = ~cpu_gated;

endmodule

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;
  localparam int BC = 2;
  localparam int BP = 4;

  logic rst_n = 1'b0;
  logic cpu_clk = 1'b0;
  logic pci_clk = 1'b0;
  logic cpu_stop_n = 1'b1;
  logic pci_stop_n = 1'b1;
  logic [BC-1:0] cpu_en = '1, cpu_st = '1;
  logic [BP-1:0] pci_en = '1, pci_st = '1;
  logic [BC-1:0] cpu_t, cpu_c, cpu_oe;
  logic [BP-1:0] pci_o, pci_oe;

  int checks = 0;
  int errors = 0;
  int cpu_pulses = 0, cpu_runts = 0, pci_pulses = 0, pci_runts = 0;

  always #2.5 cpu_clk = ~cpu_clk;
  always #7.5 pci_clk = ~pci_clk;

  clkstop_ctrl #(.N_CPU(BC), .N_PCI(BP)) u_clkstop_ctrl (
    .rst_n(rst_n), .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk),
    .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n),
    .cpu_en_i(cpu_en), .cpu_stoppable_i(cpu_st),
    .pci_en_i(pci_en), .pci_stoppable_i(pci_st),
    .cpu_t_o(cpu_t), .cpu_c_o(cpu_c), .cpu_oe_o(cpu_oe),
    .pci_o(pci_o), .pci_oe_o(pci_oe)
  );

  // R8 pulse-width monitors: every high pulse must last one half period
  for (genvar g = 0; g < BC; g++) begin : g_cmon
    realtime rt = -1.0;
    always @(posedge cpu_t[g]) rt = $realtime;
    always @(negedge cpu_t[g]) if (rt >= 0.0) begin
      cpu_pulses++;
      if (($realtime - rt) < 2.49 || ($realtime - rt) > 2.51) cpu_runts++;
    end
  end
  for (genvar g = 0; g < BP; g++) begin : g_pmon
    realtime rt = -1.0;
    always @(posedge pci_o[g]) rt = $realtime;
    always @(negedge pci_o[g]) if (rt >= 0.0) begin
      pci_pulses++;
      if (($realtime - rt) < 7.49 || ($realtime - rt) > 7.51) pci_runts++;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_hi(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge cpu_clk);
      #1;
    end
  endtask

  task automatic pci_hi(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge pci_clk);
      #1;
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] en, input logic [7:0] st,
                                       input logic stop);
    return stop ? (en & ~st) : en;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    #4;
    check("R10 cpu oe in reset", 8'(cpu_oe), 8'h00);
    check("R10 cpu true in reset", 8'(cpu_t), 8'h00);
    #8;
    check("R10 pci in reset", 8'(pci_o), 8'h00);
    #9 rst_n = 1'b1;

    // CPU sweep: R2 R3 R7 R9
    cpu_hi(1);
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 2; p++) begin
          logic [7:0] x;
          cpu_en = 2'(e); cpu_st = 2'(s); cpu_stop_n = ~1'(p);
          cpu_hi(3);
          x = model(8'(e), 8'(s), 1'(p)) & 8'h03;
          check("R2 cpu true level", 8'(cpu_t), x);
          check("R3 cpu oe", 8'(cpu_oe), x);
          check("R9 cpu complement", 8'(cpu_c & cpu_oe), 8'(~cpu_t & cpu_oe));
          if (e == 0) check("R7 cpu disabled floats", 8'(cpu_oe), 8'h00);
        end

    // CPU exact latency: R1 R4
    cpu_en = '1; cpu_st = 2'b01; cpu_stop_n = 1'b1;
    cpu_hi(3);
    cpu_stop_n = 1'b0;
    cpu_hi(1);
    check("R1 cpu first edge passes", 8'(cpu_t), 8'h03);
    cpu_hi(1);
    check("R1 cpu second edge gated", 8'(cpu_t), 8'h02);
    check("R3 cpu stopped floats", 8'(cpu_oe), 8'h02);
    cpu_stop_n = 1'b1;
    cpu_hi(1);
    check("R4 cpu not yet resumed", 8'(cpu_t), 8'h02);
    cpu_hi(1);
    check("R4 cpu resumed", 8'(cpu_t), 8'h03);

    // PCI sweep: R5 R7
    pci_hi(1);
    for (int e = 0; e < 16; e++)
      for (int s = 0; s < 16; s++)
        for (int p = 0; p < 2; p++) begin
          logic [7:0] x;
          pci_en = 4'(e); pci_st = 4'(s); pci_stop_n = ~1'(p);
          pci_hi(3);
          x = model(8'(e), 8'(s), 1'(p)) & 8'h0F;
          check("R5 pci level", 8'(pci_o), x);
          if (e == 0) check("R7 pci disabled low", 8'(pci_o), 8'h00);
        end
    check("R5 pci stays driven", 8'(pci_oe), 8'h0F);

    // PCI exact latency: R5 R6
    pci_en = '1; pci_st = 4'b0101; pci_stop_n = 1'b1;
    pci_hi(3);
    pci_stop_n = 1'b0;
    pci_hi(1);
    check("R5 pci first edge passes", 8'(pci_o), 8'h0F);
    pci_hi(1);
    check("R5 pci second edge gated", 8'(pci_o), 8'h0A);
    pci_stop_n = 1'b1;
    pci_hi(1);
    check("R6 pci not yet resumed", 8'(pci_o), 8'h0A);
    pci_hi(1);
    check("R6 pci resumed", 8'(pci_o), 8'h0F);
    #3;
    check("R9 cpu complement low phase", 8'(cpu_c & cpu_oe), 8'(~cpu_t & cpu_oe));

    // R8 summary of the pulse monitors
    check("R8 cpu pulses seen", 8'(cpu_pulses > 0), 8'h01);
    check("R8 cpu runt pulses", 8'(cpu_runts), 8'h00);
    check("R8 pci pulses seen", 8'(pci_pulses > 0), 8'h01);
    check("R8 pci runt pulses", 8'(pci_runts), 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule